// File: doc/BRIEF.md
# Picture-in-Picture DMA Address Generator

This block drives the address side of a memory-to-memory DMA channel that copies a rectangular window out of a larger frame. Software supplies a start address for the read side and for the write side, a transfer width code, a total length in bytes, a row length in transfer units, and a separate hole value for each side. When the enable pulse arrives, the block captures all of these. It then presents one read/write address pair per beat until every beat has been accepted.

Inside a row, both addresses step by one transfer unit. After the last beat of a row, each side instead jumps by its own hole times the unit size. This skips the part of that side's frame outside the window. The row length is shared by both sides, so a window can be moved between frames of different strides.

A beat is offered with a valid/ready handshake. The address pair is held steady until the beat is taken. A one-cycle done pulse marks the end of the transfer. A configuration that cannot be run is rejected with a one-cycle error pulse, and no beats are issued.

Top module: `pip_addr_gen`

## Requirements
- R1: On `start` while idle with a legal configuration, the first beat appears on the next cycle with `rd_addr` equal to `src_base` and `wr_addr` equal to `dst_base`.
- R2: Within a row, each accepted beat advances both addresses by one unit of 1 << `xfer_width` bytes (code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R3: After the accepted beat that completes a row of `row_len` beats, the read address advances by `src_hole` units and the write address by `dst_hole` units. A hole of 1 therefore means no gap.
- R4: The transfer issues exactly `byte_len >> xfer_width` beats.
- R5: A beat count larger than `MAX_BEATS` raises `cfg_err` for one cycle after `start`, and no beat is issued.
- R6: A `row_len` of zero, a width code of 3, or a beat count of zero each raise `cfg_err` for one cycle after `start`, and no beat is issued.
- R7: While `beat_valid` is high and `beat_ready` is low, both addresses and `beat_valid` hold.
- R8: `done` is high for exactly the one cycle after the final beat is accepted. In that cycle `busy` and `beat_valid` are already low.
- R9: A `start` pulse during a transfer is ignored, and changes to the configuration inputs during a transfer have no effect on the address sequence.
- R10: Addresses wrap modulo 2^32.
- R11: After reset, `busy`, `beat_valid`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Enable pulse; configuration is captured on this cycle |
| src_base | input | 32 | Read-side start address |
| dst_base | input | 32 | Write-side start address |
| xfer_width | input | 2 | Transfer width code (0 = byte, 1 = halfword, 2 = word) |
| byte_len | input | LEN_W | Total length in bytes |
| row_len | input | ROW_W | Beats per row |
| src_hole | input | HOLE_W | Read-side row jump in units (gap + 1) |
| dst_hole | input | HOLE_W | Write-side row jump in units (gap + 1) |
| beat_valid | output | 1 | Address pair is offered |
| beat_ready | input | 1 | Consumer takes the offered pair |
| rd_addr | output | 32 | Read address of the current beat |
| wr_addr | output | 32 | Write address of the current beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final beat |
| cfg_err | output | 1 | One-cycle pulse for a rejected configuration |

## Verification
On every cycle, the bound checker checks the following:
- the in-row step and the row-end jump on each side, against the unit and holes captured at start;
- the addresses holding during a stall, and a start during a transfer leaving them untouched;
- the single-cycle done pulse that follows the final accepted beat;
- that no beat is offered while idle or after a rejected start.

Only the bench scenarios can show that the whole sequence matches a closed-form row/column address formula, including wrap past 2^32, partial last rows and different holes per side. The same holds for the exact beat count and for each of the rejection causes.

// File: rtl/pip_pkg.sv
package pip_pkg;
  localparam int ADDR_W = 32;

  // Bytes per transfer unit for a width code.
  function automatic logic [ADDR_W-1:0] unit_bytes(input logic [1:0] wcode);
    return ADDR_W'(1) << wcode;
  endfunction

  // Next address for a lane: one unit inside a row, hole units at row end.
  function automatic logic [ADDR_W-1:0] lane_next(input logic [ADDR_W-1:0] cur,
                                                  input logic [ADDR_W-1:0] hole,
                                                  input logic [1:0]        wcode,
                                                  input logic              row_end);
    logic [ADDR_W-1:0] inc;
    inc = row_end ? (hole << wcode) : unit_bytes(wcode);
    return cur + inc;
  endfunction
endpackage

// File: rtl/pip_cfg_check.sv
module pip_cfg_check #(
  parameter int LEN_W     = 16,
  parameter int ROW_W     = 12,
  parameter int MAX_BEATS = 4095
) (
  input  logic [1:0]       wcode,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [ROW_W-1:0] row_beats,
  output logic [LEN_W-1:0] beats,
  output logic             bad_cfg
);
  logic too_many, no_row, bad_code, no_beats;

  always_comb begin
    beats    = len_bytes >> wcode;
    too_many = 32'(beats) > 32'(MAX_BEATS);
    no_row   = (row_beats == '0);
    bad_code = (wcode == 2'd3);
    no_beats = (beats == '0);
    bad_cfg  = too_many | no_row | bad_code | no_beats;
  end
endmodule

// File: rtl/pip_row_ctr.sv
module pip_row_ctr #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [ROW_W-1:0] row_beats,
  output logic             row_end
);
  logic [ROW_W-1:0] pos;

  assign row_end = (pos == row_beats - ROW_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (clear)   pos <= '0;
    else if (step)    pos <= row_end ? '0 : pos + ROW_W'(1);
  end
endmodule

// File: rtl/pip_addr_lane.sv
module pip_addr_lane
  import pip_pkg::*;
#(
  parameter int HOLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  input  logic              row_end,
  input  logic [HOLE_W-1:0] hole,
  input  logic [1:0]        wcode,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= base;
    else if (step)  addr <= lane_next(addr, ADDR_W'(hole), wcode, row_end);
  end
endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen
  import pip_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int ROW_W     = 12,
  parameter int HOLE_W    = 16,
  parameter int MAX_BEATS = 4095
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       src_base,
  input  logic [31:0]       dst_base,
  input  logic [1:0]        xfer_width,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [ROW_W-1:0]  row_len,
  input  logic [HOLE_W-1:0] src_hole,
  input  logic [HOLE_W-1:0] dst_hole,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [31:0]       rd_addr,
  output logic [31:0]       wr_addr,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  localparam int NLANE = 2;

  logic [LEN_W-1:0]  beats_in;
  logic              bad_cfg;
  logic              run_q, done_q, err_q;
  logic [LEN_W-1:0]  remain_q;
  logic [1:0]        width_q;
  logic [ROW_W-1:0]  row_q;
  logic [HOLE_W-1:0] hole_q [NLANE];
  logic [HOLE_W-1:0] hole_in [NLANE];
  logic [ADDR_W-1:0] base_in [NLANE];
  logic [ADDR_W-1:0] lane_addr [NLANE];

  // Named internal events
  logic accept_start, beat_fire, last_beat, row_wrap;

  assign hole_in[0] = src_hole;
  assign hole_in[1] = dst_hole;
  assign base_in[0] = src_base;
  assign base_in[1] = dst_base;

  pip_cfg_check #(.LEN_W(LEN_W), .ROW_W(ROW_W), .MAX_BEATS(MAX_BEATS)) u_chk (
    .wcode(xfer_width), .len_bytes(byte_len), .row_beats(row_len),
    .beats(beats_in), .bad_cfg(bad_cfg)
  );

  assign accept_start = start & ~run_q & ~bad_cfg;
  assign beat_fire    = run_q & beat_ready;
  assign last_beat    = beat_fire & (remain_q == LEN_W'(1));

  pip_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .clear(accept_start), .step(beat_fire),
    .row_beats(row_q), .row_end(row_wrap)
  );

  for (genvar s = 0; s < NLANE; s++) begin : g_lane
    pip_addr_lane #(.HOLE_W(HOLE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(accept_start), .base(base_in[s]),
      .step(beat_fire), .row_end(row_wrap), .hole(hole_q[s]),
      .wcode(width_q), .addr(lane_addr[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      remain_q <= '0;
      width_q  <= '0;
      row_q    <= '0;
      for (int s = 0; s < NLANE; s++) hole_q[s] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!run_q) begin
        if (start) begin
          if (bad_cfg) begin
            err_q <= 1'b1;
          end else begin
            run_q    <= 1'b1;
            remain_q <= beats_in;
            width_q  <= xfer_width;
            row_q    <= row_len;
            for (int s = 0; s < NLANE; s++) hole_q[s] <= hole_in[s];
          end
        end
      end else if (beat_fire) begin
        remain_q <= remain_q - LEN_W'(1);
        if (last_beat) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign beat_valid = run_q;
  assign busy       = run_q;
  assign done       = done_q;
  assign cfg_err    = err_q;
  assign rd_addr    = lane_addr[0];
  assign wr_addr    = lane_addr[1];
endmodule

// File: rtl/pip_addr_gen_chk.sv
module pip_addr_gen_chk #(
  parameter int HOLE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [31:0]       rd_addr,
  input logic [31:0]       wr_addr,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic              row_wrap,
  input logic              last_beat,
  input logic [1:0]        width_q,
  input logic [HOLE_W-1:0] src_hole_q,
  input logic [HOLE_W-1:0] dst_hole_q
);
  logic fire;
  assign fire = beat_valid & beat_ready;

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !beat_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(rd_addr) && $stable(wr_addr)));

  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !row_wrap) |=> (rd_addr == $past(rd_addr) + (32'd1 << $past(width_q)) &&
                             wr_addr == $past(wr_addr) + (32'd1 << $past(width_q))));

  assert_row_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && row_wrap) |=> (rd_addr == $past(rd_addr) + (32'($past(src_hole_q)) << $past(width_q)) &&
                            wr_addr == $past(wr_addr) + (32'($past(dst_hole_q)) << $past(width_q))));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (done && !busy));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_no_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !beat_valid);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !beat_ready) |=> ($stable(rd_addr) && $stable(wr_addr)));
endmodule

bind pip_addr_gen pip_addr_gen_chk #(.HOLE_W(HOLE_W)) u_pip_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .rd_addr(rd_addr), .wr_addr(wr_addr), .busy(busy),
  .done(done), .cfg_err(cfg_err), .row_wrap(row_wrap), .last_beat(last_beat),
  .width_q(width_q), .src_hole_q(hole_q[0]), .dst_hole_q(hole_q[1])
);

// File: tb/pip_addr_gen_test.sv
module pip_addr_gen_test;
  localparam int LEN_W = 16, ROW_W = 12, HOLE_W = 16, MAX_BEATS = 4095;

  typedef struct packed {
    logic [31:0]       src;
    logic [31:0]       dst;
    logic [1:0]        w;
    logic [LEN_W-1:0]  len;
    logic [ROW_W-1:0]  bnd;
    logic [HOLE_W-1:0] sh;
    logic [HOLE_W-1:0] dh;
    logic              err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'h0000_8000, 2'd2, 16'd48,   12'd4,    16'd3, 16'd1, 1'b0}, // R2 R3 word
    '{32'h0000_0200, 32'h0000_0300, 2'd0, 16'd10,   12'd5,    16'd6, 16'd2, 1'b0}, // byte
    '{32'hFFFF_FFF8, 32'h7FFF_FFFC, 2'd1, 16'd18,   12'd3,    16'd1, 16'd5, 1'b0}, // R10 wrap
    '{32'h0000_4000, 32'h0000_5000, 2'd2, 16'd20,   12'd2,    16'd4, 16'd9, 1'b0}, // partial last row
    '{32'h0000_0000, 32'h0000_0000, 2'd2, 16'd16384,12'd4,    16'd1, 16'd1, 1'b1}, // R5 4096 beats
    '{32'h0000_0000, 32'h0000_0000, 2'd0, 16'd8,    12'd0,    16'd1, 16'd1, 1'b1}, // R6 boundary 0
    '{32'h0000_0000, 32'h0000_0000, 2'd3, 16'd8,    12'd2,    16'd1, 16'd1, 1'b1}, // R6 code 3
    '{32'h0000_0000, 32'h0000_0000, 2'd2, 16'd3,    12'd2,    16'd1, 16'd1, 1'b1}, // R6 zero beats
    '{32'h0001_0000, 32'h0002_0000, 2'd0, 16'd4095, 12'd4095, 16'd1, 16'd1, 1'b0}  // R5 max accepted
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, beat_ready = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [1:0] xfer_width = '0;
  logic [LEN_W-1:0] byte_len = '0;
  logic [ROW_W-1:0] row_len = '0;
  logic [HOLE_W-1:0] src_hole = '0, dst_hole = '0;
  logic beat_valid, busy, done, cfg_err;
  logic [31:0] rd_addr, wr_addr;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pip_addr_gen #(.LEN_W(LEN_W), .ROW_W(ROW_W), .HOLE_W(HOLE_W), .MAX_BEATS(MAX_BEATS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .xfer_width(xfer_width), .byte_len(byte_len), .row_len(row_len),
    .src_hole(src_hole), .dst_hole(dst_hole), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Closed-form address: row r, column c -> base + (r*(bnd-1+hole) + c) units.
  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int w,
                                           input int bnd, input int hole, input int i);
    longint r, c, units;
    r = i / bnd;
    c = i % bnd;
    units = r * longint'(bnd - 1 + hole) + c;
    return base + 32'(units << w);
  endfunction

  task automatic load_cfg(input vec_t v);
    src_base = v.src; dst_base = v.dst; xfer_width = v.w; byte_len = v.len;
    row_len = v.bnd; src_hole = v.sh; dst_hole = v.dh;
  endtask

  // Runs one vector; stall pattern selects ready gaps; inject issues a stray start.
  task automatic run_vec(input vec_t v, input int stall, input bit inject);
    int nb, i, cyc;
    nb = int'(v.len) >> v.w;
    @(negedge clk);
    load_cfg(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.err) begin
      check("R5/R6 cfg_err", 32'(cfg_err), 32'd1);
      check("R5/R6 no beat", 32'(beat_valid), 32'd0);
      @(negedge clk);
      check("R5/R6 still idle", 32'(busy), 32'd0);
      return;
    end
    i = 0; cyc = 0;
    while (i < nb) begin
      if (!beat_valid) begin
        check("R4 valid until last beat", 32'(beat_valid), 32'd1);
        return;
      end
      check("R1 R2 R3 R7 R10 rd_addr", rd_addr, exp_addr(v.src, int'(v.w), int'(v.bnd), int'(v.sh), i));
      check("R1 R2 R3 R7 R10 wr_addr", wr_addr, exp_addr(v.dst, int'(v.w), int'(v.bnd), int'(v.dh), i));
      beat_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (inject && i == 2) begin
        start = 1'b1;
        src_base = 32'hDEAD_0000; dst_base = 32'hBEEF_0000; xfer_width = 2'd0; src_hole = 16'd77;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (beat_ready) i++;
      cyc++;
    end
    beat_ready = 1'b0;
    start = 1'b0;
    check("R8 R4 done after final beat", 32'(done), 32'd1);
    check("R8 idle at done", 32'(beat_valid), 32'd0);
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 valid", 32'(beat_valid), 32'd0);
    check("R11 done", 32'(done), 32'd0);
    check("R11 cfg_err", 32'(cfg_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", 32'(beat_valid), 32'd0);

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k], (k % 2 == 1) ? 3 : 0, 1'b0);
    end

    // R9: stray start and changed inputs during a transfer, with stalls (R7)
    run_vec(VECS[0], 2, 1'b1);
    // R1: new transfer after done starts cleanly from its own bases
    run_vec(VECS[3], 0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule